// File: doc/BRIEF.md
# H-Bridge Control Core with Latched Fault Handling

This block is the digital decision logic of a full H-bridge driver. It drives two half-bridge legs. Each leg has a command input: a high command turns on that leg's high-side switch, and a low command turns on its low-side switch. Both legs high or both legs low is a valid braking (freewheel) state. Two disable inputs of opposite polarity can force both legs to high impedance, which means all four switches are off.

Three protection flags arrive already qualified by the analog front end: supply undervoltage, short circuit and overtemperature. A digitized junction temperature also arrives. Undervoltage shuts the bridge off only while it lasts. Short circuit and overtemperature latch the bridge off. The latch is cleared only by the release edge of a disable input, and after a thermal trip only when the die has cooled below the shutdown threshold minus its hysteresis.

All single-bit inputs pass through a two-flop synchronizer before any decision is made. Every switch-over of a leg inserts a programmable dead time during which both of its switches are off. The active-low fault status output goes low whenever the bridge is held off for any reason.

Top module: `hbridge_ctrl`

## Requirements
- R1: With the bridge running, each leg follows its own command: command 1 enables only that leg's high-side switch, and command 0 enables only its low-side switch.
- R2: Both commands at 1 (both high sides on) and both commands at 0 (both low sides on) are accepted braking states and are driven as commanded.
- R3: `dis_hi` = 1 or `dis_lo_n` = 0 turns all four enables off and drives `fault_n` to 0. Once both disables are inactive again, the legs return to the commanded state.
- R4: While `uv_flag` = 1, all enables are off and `fault_n` = 0. When it returns to 0, the commanded state resumes with no other action.
- R5: `sc_flag` = 1 or `ot_flag` = 1 latches the bridge off with `fault_n` = 0. The latch persists after the flag drops, whatever the leg commands do.
- R6: The latch clears only on a falling edge of the synchronized `dis_hi` or a rising edge of the synchronized `dis_lo_n`. Reset also clears it.
- R7: After an overtemperature trip, a clear edge is honoured only if `tj_temp` < T_SHUT − T_HYST (175 − 15 = 160 by default). At 160 or above, the bridge stays latched.
- R8: During reset and for the two synchronizer cycles after it, all enables are off and no latched fault is held.
- R9: A leg's high-side and low-side enables are never both 1. After a leg's enable drops, the leg stays fully off for exactly `dead_cycles` + 1 clock cycles before the opposite switch turns on.
- R10: When a clear edge and a new short-circuit or overtemperature flag reach the core in the same cycle, the fault wins and the bridge stays latched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset (also the power-cycle clear) |
| leg_a_cmd | input | 1 | Leg A command: 1 = high side, 0 = low side |
| leg_b_cmd | input | 1 | Leg B command: 1 = high side, 0 = low side |
| dis_hi | input | 1 | Disable, active high |
| dis_lo_n | input | 1 | Disable, active low |
| uv_flag | input | 1 | Supply undervoltage, self-clearing |
| sc_flag | input | 1 | Short circuit detected, latching |
| ot_flag | input | 1 | Overtemperature detected, latching |
| tj_temp | input | TEMP_W | Junction temperature in degrees, unsigned |
| dead_cycles | input | DT_W | Dead-time count, held static while the bridge runs |
| a_hs_en | output | 1 | Leg A high-side switch enable |
| a_ls_en | output | 1 | Leg A low-side switch enable |
| b_hs_en | output | 1 | Leg B high-side switch enable |
| b_ls_en | output | 1 | Leg B low-side switch enable |
| fault_n | output | 1 | Fault status, low while the bridge is held off |

## Verification
The bench sweeps every combination of the two commands and the two disables. A core that decoded either disable with the wrong polarity, or that blocked braking states, would miscompare in that sweep.

The latch tests check three things. Command activity and the end of the fault flag must leave the bridge off, which catches a core that forgot the latch. Both release edges must clear it. The thermal gate is probed at 160 and at 159, which catches an off-by-one comparison.

A clear edge is made to coincide with a new fault, which exposes a core that gives the clear priority. The dead time is counted exactly on a reversal, and shoot-through is monitored on every cycle, which catches a missing or shortened off gap.

// File: rtl/hb_ctrl_pkg.sv
package hb_ctrl_pkg;

  // Per-leg switch state; bit 1 = high side, bit 0 = low side
  typedef enum logic [1:0] {
    LEG_OFF = 2'b00,
    LEG_LO  = 2'b01,
    LEG_HI  = 2'b10
  } leg_mode_e;

  // Requested leg state from the run permission and the leg command
  function automatic leg_mode_e leg_request(input logic run, input logic cmd);
    if (!run) return LEG_OFF;
    return cmd ? LEG_HI : LEG_LO;
  endfunction

  // True when the die is cool enough for a thermal latch to be released
  function automatic logic temp_clear_ok(input int unsigned tj,
                                         input int unsigned shut,
                                         input int unsigned hyst);
    return (tj + hyst) < shut;
  endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int              WIDTH   = 7,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hb_fault.sv
module hb_fault #(
  parameter int TEMP_W = 8,
  parameter int T_SHUT = 175,
  parameter int T_HYST = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dis_hi_s,
  input  logic              dis_lo_n_s,
  input  logic              sc_s,
  input  logic              ot_s,
  input  logic [TEMP_W-1:0] tj,
  output logic              latched
);
  import hb_ctrl_pkg::*;

  logic prev_dis_hi, prev_dis_lo_n, ot_cause;
  logic clr_evt, temp_ok, clr_ok, set_evt;

  // Release edges of either disable (reset values match the synchronizer)
  assign clr_evt = (prev_dis_hi & ~dis_hi_s) | (~prev_dis_lo_n & dis_lo_n_s);
  assign temp_ok = temp_clear_ok(32'(tj), T_SHUT, T_HYST);
  assign clr_ok  = clr_evt & (~ot_cause | temp_ok);
  assign set_evt = sc_s | ot_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_dis_hi   <= 1'b1;
      prev_dis_lo_n <= 1'b0;
      latched       <= 1'b0;
      ot_cause      <= 1'b0;
    end else begin
      prev_dis_hi   <= dis_hi_s;
      prev_dis_lo_n <= dis_lo_n_s;
      if (set_evt) begin
        latched  <= 1'b1;
        ot_cause <= ot_cause | ot_s;
      end else if (clr_ok) begin
        latched  <= 1'b0;
        ot_cause <= 1'b0;
      end
    end
  end

  // R5 R10
  set_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> latched);

  // R6
  hold_without_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && !clr_evt) |=> latched);

  // R7
  hot_clear_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && ot_cause && !temp_ok) |=> latched);
endmodule

// File: rtl/hb_leg.sv
module hb_leg #(
  parameter int DT_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  hb_ctrl_pkg::leg_mode_e target,
  input  logic [DT_W-1:0]       dead,
  output logic                  hs_en,
  output logic                  ls_en
);
  import hb_ctrl_pkg::*;

  localparam int OL_W = DT_W + 1;

  leg_mode_e       cur;
  logic [DT_W-1:0] cnt;
  logic [OL_W-1:0] off_len;
  logic            turn_on;

  assign turn_on = (cur == LEG_OFF) && (cnt == '0) && (target != LEG_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= LEG_OFF;
      cnt <= '0;
    end else if (cur != LEG_OFF) begin
      if (target != cur) begin
        cur <= LEG_OFF;
        cnt <= dead;
      end
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else if (target != LEG_OFF) begin
      cur <= target;
    end
  end

  assign hs_en = cur[1];
  assign ls_en = cur[0];

  // Independent count of cycles spent fully off, for the dead-time check
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                off_len <= '1;
    else if (hs_en || ls_en)   off_len <= '0;
    else if (off_len != '1)    off_len <= off_len + 1'b1;
  end

  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en && ls_en));

  // R9
  dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    turn_on |-> (off_len >= {1'b0, dead}));
endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int DT_W        = 4,
  parameter int TEMP_W      = 8,
  parameter int T_SHUT      = 175,
  parameter int T_HYST      = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              leg_a_cmd,
  input  logic              leg_b_cmd,
  input  logic              dis_hi,
  input  logic              dis_lo_n,
  input  logic              uv_flag,
  input  logic              sc_flag,
  input  logic              ot_flag,
  input  logic [TEMP_W-1:0] tj_temp,
  input  logic [DT_W-1:0]   dead_cycles,
  output logic              a_hs_en,
  output logic              a_ls_en,
  output logic              b_hs_en,
  output logic              b_ls_en,
  output logic              fault_n
);
  import hb_ctrl_pkg::*;

  localparam int B_CA = 0, B_CB = 1, B_DH = 2, B_DL = 3;
  localparam int B_UV = 4, B_SC = 5, B_OT = 6;
  localparam int N_SYNC = 7;
  localparam int N_LEGS = 2;
  // Synchronizer wakes with the bridge disabled
  localparam logic [N_SYNC-1:0] SYNC_RST = N_SYNC'(1) << B_DH;

  logic [N_SYNC-1:0] raw, s;
  logic              latched, run;
  logic [N_LEGS-1:0] cmd_s, hs, ls;
  leg_mode_e         tgt [N_LEGS];

  assign raw = {ot_flag, sc_flag, uv_flag, dis_lo_n, dis_hi, leg_b_cmd, leg_a_cmd};

  hb_sync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(s));

  hb_fault #(.TEMP_W(TEMP_W), .T_SHUT(T_SHUT), .T_HYST(T_HYST)) u_fault (
    .clk(clk), .rst_n(rst_n),
    .dis_hi_s(s[B_DH]), .dis_lo_n_s(s[B_DL]),
    .sc_s(s[B_SC]), .ot_s(s[B_OT]), .tj(tj_temp),
    .latched(latched));

  assign run   = ~latched & ~s[B_UV] & ~s[B_DH] & s[B_DL];
  assign cmd_s = {s[B_CB], s[B_CA]};

  for (genvar g = 0; g < N_LEGS; g++) begin : g_leg
    assign tgt[g] = leg_request(run, cmd_s[g]);
    hb_leg #(.DT_W(DT_W)) u_leg (
      .clk(clk), .rst_n(rst_n), .target(tgt[g]), .dead(dead_cycles),
      .hs_en(hs[g]), .ls_en(ls[g]));
  end

  assign a_hs_en = hs[0];
  assign a_ls_en = ls[0];
  assign b_hs_en = hs[1];
  assign b_ls_en = ls[1];
  assign fault_n = run;

  // R3 R4 R5
  off_when_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (hs == '0 && ls == '0));
endmodule

// File: tb/hbridge_ctrl_bench.sv
`timescale 1ns/1ps
module hbridge_ctrl_bench;
  localparam int DT_W = 4, TEMP_W = 8, SETTLE = 40;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, ca, cb, dh, dln, uv, sc, ot;
  logic [TEMP_W-1:0] tj;
  logic [DT_W-1:0]   dead;
  logic a_hs, a_ls, b_hs, b_ls, fn;

  int n_vec = 0, n_bad = 0, dt_viol = 0;
  bit done = 0;

  hbridge_ctrl u_hbridge_ctrl (
    .clk(clk), .rst_n(rst_n), .leg_a_cmd(ca), .leg_b_cmd(cb),
    .dis_hi(dh), .dis_lo_n(dln), .uv_flag(uv), .sc_flag(sc), .ot_flag(ot),
    .tj_temp(tj), .dead_cycles(dead),
    .a_hs_en(a_hs), .a_ls_en(a_ls), .b_hs_en(b_hs), .b_ls_en(b_ls), .fault_n(fn));

  // Expected {a_hs, a_ls, b_hs, b_ls, fault_n}
  function automatic logic [4:0] expect_out(logic run, logic xa, logic xb);
    return {run & xa, run & ~xa, run & xb, run & ~xb, run};
  endfunction

  task automatic check(string req, logic [4:0] exp);
    logic [4:0] got;
    got = {a_hs, a_ls, b_hs, b_ls, fn};
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic check_val(string req, int got, int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(posedge clk);
    @(negedge clk);
  endtask

  // Dead-time and overlap monitor for R9
  int   off_run [2];
  logic was_on  [2];
  initial begin
    for (int i = 0; i < 2; i++) begin off_run[i] = 1000; was_on[i] = 1'b0; end
  end
  always @(negedge clk) if (rst_n) begin
    logic hs_v [2];
    logic ls_v [2];
    hs_v[0] = a_hs; ls_v[0] = a_ls; hs_v[1] = b_hs; ls_v[1] = b_ls;
    for (int i = 0; i < 2; i++) begin
      if (hs_v[i] && ls_v[i]) dt_viol++;
      if (hs_v[i] || ls_v[i]) begin
        if (!was_on[i] && off_run[i] < int'(dead) + 1) dt_viol++;
        off_run[i] = 0;
        was_on[i]  = 1'b1;
      end else begin
        off_run[i]++;
        was_on[i] = 1'b0;
      end
    end
  end

  // Release the disable through dis_hi (a falling edge)
  task automatic pulse_dis_hi();
    dh = 1'b1; settle();
    dh = 1'b0; settle();
  endtask

  task automatic pulse_dis_lo();
    dln = 1'b0; settle();
    dln = 1'b1; settle();
  endtask

  initial begin
    rst_n = 1'b0; ca = 0; cb = 0; dh = 0; dln = 1; uv = 0; sc = 0; ot = 0;
    tj = 8'd25; dead = 4'd3;
    repeat (4) @(negedge clk);
    // R8: reset holds everything off
    check("R8 in reset", 5'b00000);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R8 sync delay", 5'b00000);
    settle();
    check("R8 runs after sync", expect_out(1, 0, 0));

    // R1 R2 R3: sweep disables and commands
    for (int v = 0; v < 16; v++) begin
      dh = v[3]; dln = v[2]; ca = v[1]; cb = v[0];
      settle();
      check($sformatf("R1 R2 R3 sweep dh=%0d dln=%0d a=%0d b=%0d", v[3], v[2], v[1], v[0]),
            expect_out(!v[3] && v[2], v[1], v[0]));
    end
    dh = 0; dln = 1; ca = 1; cb = 0; settle();
    check("R1 forward", expect_out(1, 1, 0));

    // R4: undervoltage self-clears
    uv = 1; settle();
    check("R4 uv off", 5'b00000);
    uv = 0; settle();
    check("R4 uv recovery", expect_out(1, 1, 0));

    // R5 R6: short-circuit latch survives flag removal and command activity
    sc = 1; settle();
    check("R5 sc latch", 5'b00000);
    sc = 0; settle();
    check("R5 sc held", 5'b00000);
    ca = 0; cb = 1; settle(); ca = 1; cb = 1; settle();
    check("R6 commands ignored", 5'b00000);
    pulse_dis_hi();
    check("R6 clear via dis_hi fall", expect_out(1, 1, 1));
    sc = 1; settle(); sc = 0; settle();
    check("R5 sc relatch", 5'b00000);
    pulse_dis_lo();
    check("R6 clear via dis_lo_n rise", expect_out(1, 1, 1));

    // R7: thermal gate boundary
    ot = 1; tj = 8'd180; settle(); ot = 0; settle();
    check("R7 ot latch", 5'b00000);
    tj = 8'd160; pulse_dis_hi();
    check("R7 tj=160 stays latched", 5'b00000);
    tj = 8'd159; pulse_dis_hi();
    check("R7 tj=159 clears", expect_out(1, 1, 1));

    // R10: clear edge and new fault coincide
    sc = 1; settle(); sc = 0; settle();
    dh = 1; settle();
    @(negedge clk); dh = 0; sc = 1;
    settle(); sc = 0; settle();
    check("R10 fault wins", 5'b00000);
    pulse_dis_lo();
    check("R10 later clear", expect_out(1, 1, 1));

    // R9: exact dead gap on a reversal (leg A high -> low -> high)
    dh = 1; settle(); dead = 4'd5; dh = 0; ca = 0; settle();
    @(negedge clk); ca = 1;
    begin
      int gap = 0;
      for (int k = 0; k < 60; k++) begin
        @(negedge clk);
        if (!a_hs && !a_ls) gap++;
        if (a_hs) break;
      end
      check_val("R9 dead gap dead=5", gap, 6);
    end
    dh = 1; settle(); dead = 4'd0; dh = 0; settle();
    for (int k = 0; k < 8; k++) begin
      ca = ~ca; cb = ca;
      repeat (12) @(negedge clk);
    end
    settle();
    check_val("R9 overlap/dead monitor", dt_viol, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule